// File: doc/BRIEF.md
# Card Data-Wait Timeout Counter

This block supervises the data phase of a memory-card transfer. A controller starts a wait window each time it expects the card to send or accept data. If the programmed number of count units passes before any data activity is reported, the block raises a sticky timeout status bit. The bit stays set until software acknowledges it.

The limit is held in a 16-bit register together with a unit-select bit. When the unit bit is clear, one count unit is one card-clock cycle. When it is set, one unit is 1024 card-clock cycles. A limit of zero disables expiry, so the block waits without end. A combinational helper builds the register form from a requested wait. The requested wait is a cycle term plus a nanosecond term, and the nanosecond term is divided by the card-clock period (base period times divider). A load pulse copies the helper's result into the registers.

The block runs on a system clock. Card-clock cycles arrive as a one-cycle enable, `card_tick`.

Top module: `card_dto_timer`

## Requirements
- R1: After reset, `dto_flag`, `win_armed`, `cfg_limit` and `cfg_kilo` are all 0.
- R2: On `cfg_load`, a requested total T below 0xFFFF is stored as `cfg_limit` = T with `cfg_kilo` = 0. Both are visible in the cycle after the load edge.
- R3: On `cfg_load`, a total T of 0xFFFF or more is stored as `cfg_limit` = (T >> 10) + 1 with `cfg_kilo` = 1.
- R4: If (T >> 10) + 1 exceeds 0xFFFF, the load stores `cfg_limit` = 0 with `cfg_kilo` = 1.
- R5: T = `req_cycles` + floor(`req_ns` / (`clk_period_ns` × `clk_div`)). When the product is zero, the nanosecond term is 0.
- R6: In cycle units (`cfg_kilo` = 0), a `win_start` with limit N > 0 arms the window. `dto_flag` is set at the clock edge of the N-th `card_tick` that follows the start cycle, and `win_armed` falls at that same edge.
- R7: In kilocycle units, a unit passes on every 1024th `card_tick`. A 10-bit free-running prescaler produces these units, and every `win_start` clears it. A tick in the start cycle itself is not counted.
- R8: A `win_start` while `cfg_limit` is 0 leaves `win_armed` low, and `dto_flag` is never set by that window.
- R9: `data_seen` without `win_start` disarms the window. No timeout follows from that window.
- R10: `win_start` during an armed window reloads the count from `cfg_limit` and takes priority over `data_seen` in the same cycle.
- R11: `dto_flag` stays set until a `flag_ack` pulse clears it. If an expiry and `flag_ack` occur in the same cycle, the flag is set.
- R12: `card_tick` pulses while no window is armed leave `dto_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Copy the helper result into the limit and unit registers |
| req_cycles | input | 32 | Requested wait, cycle term |
| req_ns | input | 32 | Requested wait, nanosecond term |
| clk_period_ns | input | 8 | Base clock period in ns |
| clk_div | input | 10 | Card-clock divider |
| win_start | input | 1 | Start (or restart) a data-wait window |
| data_seen | input | 1 | Data activity arrived; end the window |
| card_tick | input | 1 | One card-clock cycle has elapsed |
| flag_ack | input | 1 | Write-one-to-clear acknowledge of the timeout flag |
| cfg_limit | output | 16 | Stored limit register |
| cfg_kilo | output | 1 | Stored unit bit (1 = 1024-cycle units) |
| win_armed | output | 1 | A window is counting |
| dto_flag | output | 1 | Sticky data-timeout status |

## Verification
Two kinds of internal fault show up at the ports. A count that is off by one moves the rising edge of `dto_flag` by one unit. In cycle mode that shift appears at the expiry edge itself. A prescaler that is not cleared at a start, or that wraps at the wrong value, shifts expiry in kilocycle mode by up to 1023 ticks. A wrong encoder threshold shows up in `cfg_limit` and `cfg_kilo` one cycle after the load. A behavioural model in the bench follows every edge, so the first cycle in which the flag, the armed bit or the registers disagree with the model is reported.

// File: rtl/dto_pkg.sv
package dto_pkg;
   typedef enum logic {
      UNIT_CYCLE = 1'b0,
      UNIT_KILO  = 1'b1
   } unit_mode_e;

   localparam int unsigned DEF_LIMIT_W = 16;
   localparam int unsigned DEF_PRE_W   = 10;
   localparam int unsigned DEF_REQ_W   = 32;
   localparam int unsigned DEF_PER_W   = 8;
   localparam int unsigned DEF_DIV_W   = 10;
endpackage

// File: rtl/dto_limit_encoder.sv
module dto_limit_encoder
   import dto_pkg::*;
#(
   parameter int unsigned REQ_W   = DEF_REQ_W,
   parameter int unsigned LIMIT_W = DEF_LIMIT_W,
   parameter int unsigned PRE_W   = DEF_PRE_W,
   parameter int unsigned PER_W   = DEF_PER_W,
   parameter int unsigned DIV_W   = DEF_DIV_W,
   parameter bit          KILO_EN = 1'b1
) (
   input  logic [REQ_W-1:0]   req_cycles,
   input  logic [REQ_W-1:0]   req_ns,
   input  logic [PER_W-1:0]   clk_period_ns,
   input  logic [DIV_W-1:0]   clk_div,
   output logic [LIMIT_W-1:0] enc_limit,
   output unit_mode_e         enc_mode
);
   localparam int unsigned PROD_W = PER_W + DIV_W;
   localparam int unsigned SUM_W  = REQ_W + 1;
   localparam logic [SUM_W-1:0] DIRECT_MAX =
      {{(SUM_W-LIMIT_W){1'b0}}, {LIMIT_W{1'b1}}};

   if (REQ_W < PROD_W) begin : g_chk_prod
      $error("dto_limit_encoder: REQ_W must cover the period*divider product");
   end
   if (REQ_W < LIMIT_W) begin : g_chk_req
      $error("dto_limit_encoder: REQ_W must be at least LIMIT_W");
   end

   logic [PROD_W-1:0] unit_ns;
   logic [REQ_W-1:0]  unit_ns_x;
   logic [REQ_W-1:0]  ns_cycles;
   logic [SUM_W-1:0]  total;

   assign unit_ns   = {{DIV_W{1'b0}}, clk_period_ns} * {{PER_W{1'b0}}, clk_div};
   assign unit_ns_x = {{(REQ_W-PROD_W){1'b0}}, unit_ns};

   always_comb begin
      if (unit_ns == '0) ns_cycles = '0;
      else               ns_cycles = req_ns / unit_ns_x;
   end

   assign total = {1'b0, req_cycles} + {1'b0, ns_cycles};

   if (KILO_EN) begin : g_scaled
      logic [SUM_W-1:0] scaled;
      assign scaled = (total >> PRE_W) + {{(SUM_W-1){1'b0}}, 1'b1};
      always_comb begin
         if (total < DIRECT_MAX) begin
            enc_limit = total[LIMIT_W-1:0];
            enc_mode  = UNIT_CYCLE;
         end else begin
            enc_mode  = UNIT_KILO;
            if (scaled > DIRECT_MAX) enc_limit = '0;
            else                     enc_limit = scaled[LIMIT_W-1:0];
         end
      end
   end else begin : g_saturate
      always_comb begin
         enc_mode = UNIT_CYCLE;
         if (total < DIRECT_MAX) enc_limit = total[LIMIT_W-1:0];
         else                    enc_limit = DIRECT_MAX[LIMIT_W-1:0];
      end
   end
endmodule

// File: rtl/dto_prescaler.sv
module dto_prescaler
   import dto_pkg::*;
#(
   parameter int unsigned PRE_W = DEF_PRE_W
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   output logic wrap
);
   if (PRE_W < 1) begin : g_chk
      $error("dto_prescaler: PRE_W must be at least 1");
   end

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else if (tick)    pre_q <= pre_q + 1'b1;
   end

   assign wrap = tick && !restart && (&pre_q);

   AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> !wrap); // R7
endmodule

// File: rtl/dto_window_counter.sv
module dto_window_counter
   import dto_pkg::*;
#(
   parameter int unsigned LIMIT_W = DEF_LIMIT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cancel,
   input  logic               unit_tick,
   input  logic [LIMIT_W-1:0] limit,
   output logic               armed,
   output logic               expire
);
   localparam logic [LIMIT_W-1:0] ONE = {{(LIMIT_W-1){1'b0}}, 1'b1};

   logic [LIMIT_W-1:0] cnt_q;

   assign expire = armed && unit_tick && !start && !cancel && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         armed <= 1'b0;
      end else if (start) begin
         cnt_q <= limit;
         armed <= (limit != '0);
      end else if (cancel) begin
         armed <= 1'b0;
      end else if (armed && unit_tick) begin
         cnt_q <= cnt_q - ONE;
         if (cnt_q == ONE) armed <= 1'b0;
      end
   end

   AST_ARMED_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cnt_q != '0)); // R6
   AST_CANCEL_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel && !start) |=> !armed); // R9
endmodule

// File: rtl/dto_status_flag.sv
module dto_status_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (ack) flag <= 1'b0;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !ack) |=> flag); // R11
   AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag); // R11
endmodule

// File: rtl/card_dto_timer.sv
module card_dto_timer
   import dto_pkg::*;
#(
   parameter int unsigned REQ_W   = DEF_REQ_W,
   parameter int unsigned LIMIT_W = DEF_LIMIT_W,
   parameter int unsigned PRE_W   = DEF_PRE_W,
   parameter int unsigned PER_W   = DEF_PER_W,
   parameter int unsigned DIV_W   = DEF_DIV_W,
   parameter bit          KILO_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_load,
   input  logic [REQ_W-1:0]   req_cycles,
   input  logic [REQ_W-1:0]   req_ns,
   input  logic [PER_W-1:0]   clk_period_ns,
   input  logic [DIV_W-1:0]   clk_div,
   input  logic               win_start,
   input  logic               data_seen,
   input  logic               card_tick,
   input  logic               flag_ack,
   output logic [LIMIT_W-1:0] cfg_limit,
   output logic               cfg_kilo,
   output logic               win_armed,
   output logic               dto_flag
);
   localparam logic [LIMIT_W-1:0] KILO_FLOOR =
      LIMIT_W'({LIMIT_W{1'b1}} >> PRE_W);

   if (LIMIT_W < 2) begin : g_chk_limit
      $error("card_dto_timer: LIMIT_W must be at least 2");
   end
   if (PRE_W >= LIMIT_W) begin : g_chk_pre
      $error("card_dto_timer: PRE_W must be below LIMIT_W");
   end

   logic [LIMIT_W-1:0] enc_limit;
   unit_mode_e         enc_mode;
   unit_mode_e         mode_q;
   logic               unit_tick;
   logic               expire;

   dto_limit_encoder #(
      .REQ_W(REQ_W), .LIMIT_W(LIMIT_W), .PRE_W(PRE_W),
      .PER_W(PER_W), .DIV_W(DIV_W), .KILO_EN(KILO_EN)
   ) u_enc (
      .req_cycles    (req_cycles),
      .req_ns        (req_ns),
      .clk_period_ns (clk_period_ns),
      .clk_div       (clk_div),
      .enc_limit     (enc_limit),
      .enc_mode      (enc_mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_limit <= '0;
         mode_q    <= UNIT_CYCLE;
      end else if (cfg_load) begin
         cfg_limit <= enc_limit;
         mode_q    <= enc_mode;
      end
   end

   assign cfg_kilo = (mode_q == UNIT_KILO);

   if (KILO_EN) begin : g_kilo
      logic pre_wrap;
      dto_prescaler #(.PRE_W(PRE_W)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (win_start),
         .tick    (card_tick),
         .wrap    (pre_wrap)
      );
      assign unit_tick = (mode_q == UNIT_KILO) ? pre_wrap : card_tick;
   end else begin : g_plain
      assign unit_tick = card_tick;
   end

   dto_window_counter #(.LIMIT_W(LIMIT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (win_start),
      .cancel    (data_seen),
      .unit_tick (unit_tick),
      .limit     (cfg_limit),
      .armed     (win_armed),
      .expire    (expire)
   );

   dto_status_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (expire),
      .ack   (flag_ack),
      .flag  (dto_flag)
   );

   AST_ZERO_LIMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start && cfg_limit == '0) |=> !win_armed); // R8
   AST_ENC_DIRECT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_mode == UNIT_CYCLE && KILO_EN) |-> (enc_limit != '1)); // R2
   AST_ENC_KILO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_mode == UNIT_KILO && enc_limit != '0) |-> (enc_limit > KILO_FLOOR)); // R3
   AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_armed && !flag_ack) |=> ($past(dto_flag) || !dto_flag)); // R12
endmodule

// File: tb/card_dto_timer_tb.sv
module card_dto_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] req_cycles = '0;
   logic [31:0] req_ns = '0;
   logic [7:0]  clk_period_ns = '0;
   logic [9:0]  clk_div = '0;
   logic        win_start = 1'b0;
   logic        data_seen = 1'b0;
   logic        card_tick = 1'b0;
   logic        flag_ack = 1'b0;
   logic [15:0] cfg_limit;
   logic        cfg_kilo;
   logic        win_armed;
   logic        dto_flag;

   int n_checks = 0;
   int n_errors = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   card_dto_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
      .req_cycles(req_cycles), .req_ns(req_ns),
      .clk_period_ns(clk_period_ns), .clk_div(clk_div),
      .win_start(win_start), .data_seen(data_seen),
      .card_tick(card_tick), .flag_ack(flag_ack),
      .cfg_limit(cfg_limit), .cfg_kilo(cfg_kilo),
      .win_armed(win_armed), .dto_flag(dto_flag)
   );

   // behavioural reference
   longint m_limit = 0;
   int     m_kilo = 0, m_armed = 0, m_flag = 0, m_pre = 0;
   longint m_cnt = 0;

   task automatic ref_enc(input longint cyc, input longint ns, input longint per,
                          input longint dv, output longint lim, output int k);
      longint u, t;
      u = per * dv;
      t = cyc + ((u == 0) ? 0 : ns / u);
      if (t < 65535) begin lim = t; k = 0; end
      else begin
         lim = (t >> 10) + 1; k = 1;
         if (lim > 65535) lim = 0;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_limit = 0; m_kilo = 0; m_armed = 0; m_flag = 0; m_pre = 0; m_cnt = 0;
      end else begin
         longint n_lim; int n_k; int unit; int expire;
         unit = card_tick && !win_start && (m_kilo == 0 || m_pre == 1023);
         expire = 0;
         if (win_start) begin
            m_cnt = m_limit; m_armed = (m_limit != 0);
         end else if (data_seen) begin
            m_armed = 0;
         end else if (m_armed && unit) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_armed = 0; expire = 1; end
         end
         if (expire) m_flag = 1; else if (flag_ack) m_flag = 0;
         if (win_start) m_pre = 0; else if (card_tick) m_pre = (m_pre + 1) % 1024;
         if (cfg_load) begin
            ref_enc(req_cycles, req_ns, clk_period_ns, clk_div, n_lim, n_k);
            m_limit = n_lim; m_kilo = n_k;
         end
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      if (rst_n) begin
         chk(cur_req, "model dto_flag", dto_flag, m_flag);
         chk(cur_req, "model win_armed", win_armed, m_armed);
         chk(cur_req, "model cfg_limit", cfg_limit, m_limit);
         chk(cur_req, "model cfg_kilo", cfg_kilo, m_kilo);
      end
   endtask

   task automatic load(input longint cyc, input longint ns, input int per, input int dv);
      req_cycles = cyc[31:0]; req_ns = ns[31:0];
      clk_period_ns = per[7:0]; clk_div = dv[9:0];
      cfg_load = 1'b1; step(); cfg_load = 1'b0;
   endtask

   task automatic start_win();
      win_start = 1'b1; step(); win_start = 1'b0;
   endtask

   task automatic ack();
      flag_ack = 1'b1; step(); flag_ack = 1'b0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   initial begin
      #1;
      cur_req = "R1";
      chk("R1", "reset dto_flag", dto_flag, 0);
      chk("R1", "reset win_armed", win_armed, 0);
      chk("R1", "reset cfg_limit", cfg_limit, 0);
      chk("R1", "reset cfg_kilo", cfg_kilo, 0);
      run(2);
      rst_n = 1'b1;
      step();

      // R2 direct encoding
      cur_req = "R2";
      load(5, 0, 0, 0);
      chk("R2", "limit 5", cfg_limit, 5);
      chk("R2", "kilo 0", cfg_kilo, 0);
      load(32'hFFFE, 0, 0, 0);
      chk("R2", "limit FFFE", cfg_limit, 16'hFFFE);
      chk("R2", "kilo FFFE", cfg_kilo, 0);

      // R3 scaled encoding
      cur_req = "R3";
      load(32'hFFFF, 0, 0, 0);
      chk("R3", "limit from FFFF", cfg_limit, 64);
      chk("R3", "kilo from FFFF", cfg_kilo, 1);
      load(32'h3FFF800, 0, 0, 0);
      chk("R3", "limit top", cfg_limit, 16'hFFFF);

      // R4 overflow -> unlimited
      cur_req = "R4";
      load(32'h3FFFC00, 0, 0, 0);
      chk("R4", "limit overflow", cfg_limit, 0);
      chk("R4", "kilo overflow", cfg_kilo, 1);

      // R5 nanosecond term
      cur_req = "R5";
      load(10, 1000, 50, 2);
      chk("R5", "ns term", cfg_limit, 20);
      load(10, 1000, 50, 0);
      chk("R5", "zero divider", cfg_limit, 10);
      load(3, 999, 10, 10);
      chk("R5", "floor", cfg_limit, 12);

      // R6 cycle units, dense ticks
      cur_req = "R6";
      load(5, 0, 0, 0);
      card_tick = 1'b1;
      start_win();
      chk("R6", "armed after start", win_armed, 1);
      run(4);
      chk("R6", "no flag after 4 ticks", dto_flag, 0);
      step();
      chk("R6", "flag at 5th tick", dto_flag, 1);
      chk("R6", "disarmed at expiry", win_armed, 0);

      // R12 ticks while idle, flag stays
      cur_req = "R12";
      run(10);
      chk("R12", "flag held while idle", dto_flag, 1);
      ack();
      chk("R11", "ack clears flag", dto_flag, 0);
      run(10);
      chk("R12", "no flag from idle ticks", dto_flag, 0);

      // R6 sparse ticks
      cur_req = "R6";
      card_tick = 1'b0;
      start_win();
      for (int i = 0; i < 5; i++) begin
         card_tick = 1'b1; step(); card_tick = 1'b0; step(); step();
      end
      chk("R6", "flag after sparse ticks", dto_flag, 1);
      ack();

      // R11 set beats ack
      cur_req = "R11";
      load(1, 0, 0, 0);
      start_win();
      card_tick = 1'b1; flag_ack = 1'b1; step(); flag_ack = 1'b0; card_tick = 1'b0;
      chk("R11", "set wins over ack", dto_flag, 1);
      run(3);
      chk("R11", "sticky", dto_flag, 1);
      ack();
      chk("R11", "cleared", dto_flag, 0);

      // R9 data activity cancels
      cur_req = "R9";
      load(6, 0, 0, 0);
      card_tick = 1'b1;
      start_win();
      run(3);
      data_seen = 1'b1; step(); data_seen = 1'b0;
      chk("R9", "disarmed", win_armed, 0);
      run(20);
      chk("R9", "no flag after cancel", dto_flag, 0);

      // R10 restart reloads; start beats data_seen
      cur_req = "R10";
      start_win();
      run(4);
      win_start = 1'b1; data_seen = 1'b1; step(); win_start = 1'b0; data_seen = 1'b0;
      chk("R10", "armed after restart", win_armed, 1);
      run(5);
      chk("R10", "no flag 5 after restart", dto_flag, 0);
      step();
      chk("R10", "flag 6 after restart", dto_flag, 1);
      ack();

      // R8 limit zero never expires
      cur_req = "R8";
      load(0, 0, 0, 0);
      start_win();
      chk("R8", "not armed", win_armed, 0);
      run(50);
      chk("R8", "no flag", dto_flag, 0);
      load(32'h4000000, 0, 0, 0);
      start_win();
      run(3000);
      chk("R8", "no flag kilo unlimited", dto_flag, 0);

      // R7 kilocycle units, restart clears prescaler
      cur_req = "R7";
      load(32'hFFFF, 0, 0, 0);
      start_win();
      run(700);
      start_win();
      run(64 * 1024 - 1);
      chk("R7", "no flag one tick early", dto_flag, 0);
      chk("R7", "still armed", win_armed, 1);
      step();
      chk("R7", "flag at 65536 ticks", dto_flag, 1);
      card_tick = 1'b0;
      ack();
      run(3);
      summary();
   end
endmodule